// File: doc/BRIEF.md
# Bus Cycle Wait-State and Time-Out Sequencer

This block times single memory bus cycles for a DMA master. A cycle is requested with a valid/ready handshake. The request carries a 2-bit software wait-state count, a time-out disable bit and a tag that names the transfer phase. The phases are parameter-block fetch, result-block write and data transfer.

Every cycle starts with a fixed base transfer of four clocks. The programmed software wait states are added next. After that the cycle holds in hardware wait until the READY input is seen high, and then ends with a one-clock done pulse.

While the time-out is armed, 512 consecutive READY-low samples end the cycle with a one-clock abort pulse instead. On an abort, a fault code that names the phase of the aborted cycle is latched. The master uses this code to choose which block to fetch, write or transfer again. The master also generates all addresses and performs any retry.

Back-pressure works as follows. `req_ready` is high only while no cycle is in flight. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_valid` may be held high at any time without effect while `req_ready` is low.

Top module: `bcyc_ctrl`

## Requirements
- R1: During and after reset, `req_ready` is 1, `cyc_done` and `cyc_abort` are 0, and `flt_code` is 00.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `req_ready` stays low from that edge until the edge that ends the cycle.
- R3: With `ws_sel`=00 and READY high, `cyc_done` is high during the clock after the 4th rising edge that follows the acceptance edge.
- R4: `ws_sel` values 00, 01, 10 and 11 delay the first READY sample, and therefore the end of the cycle, by 0, 1, 2 and 3 clocks.
- R5: Each READY-low sample in hardware wait extends the cycle by one clock. The cycle completes on the first high sample, at 4 + waits + (number of low samples) edges after acceptance.
- R6: With `tmo_off`=0, 512 consecutive READY-low samples end the cycle with `cyc_abort` and no `cyc_done`. The abort is visible after edge 4 + waits + 511 from acceptance.
- R7: If READY is high on the 512th sample, the cycle ends with `cyc_done` and not with `cyc_abort`.
- R8: On an abort, `flt_code` takes a value from the tag sampled at acceptance: 00 gives 01 (parameter fetch), 01 gives 10 (result write), and 10 or 11 gives 11 (data). `flt_code` then holds until the next abort, whatever cycles complete in between.
- R9: With `tmo_off`=1, no abort occurs, and the cycle waits for READY for as long as it takes (tested over 700 low samples).
- R10: `ws_sel`, `tmo_off` and `phase_tag` are sampled only at acceptance. Changing them during a cycle does not alter its length, its outcome or its fault code.
- R11: `cyc_done` and `cyc_abort` are single-clock pulses, never high together, and exactly one of them occurs per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request |
| req_ready | output | 1 | High while idle; request accepted when both high |
| ws_sel | input | 2 | Software wait states 0..3 |
| tmo_off | input | 1 | 1 disables the READY time-out |
| phase_tag | input | 2 | 00 parameter fetch, 01 result write, 1x data |
| rdy_in | input | 1 | Memory READY, sampled during hardware wait |
| cyc_done | output | 1 | One-clock pulse: cycle completed |
| cyc_abort | output | 1 | One-clock pulse: cycle timed out |
| flt_code | output | 2 | Phase fault code of the last abort |

## Verification
A wrong state or counter shows up at the ports as a `cyc_done` or `cyc_abort` pulse on the wrong edge. The bench compares the exact edge index of each pulse with the value computed from the requirements, so an off-by-one error is reported on the cycle it happens.

A time-out counter that is not cleared, or that saturates wrongly, makes a later request abort early or complete late. This is caught on the first long-wait case.

A fault kind that was latched wrongly, or that is not held, appears in `flt_code` right after the abort or after a later cycle completes normally. A pulse that fires with no request waiting for one is flagged at once.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_SOFT = 2'd2,
    ST_HARD = 2'd3
  } bcyc_st_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_PARAM  = 2'd1,
    FLT_RESULT = 2'd2,
    FLT_DATA   = 2'd3
  } bcyc_flt_e;

  function automatic bcyc_flt_e tag_to_flt(input logic [1:0] tag);
    case (tag)
      2'b00:   return FLT_PARAM;
      2'b01:   return FLT_RESULT;
      default: return FLT_DATA;
    endcase
  endfunction
endpackage

// File: rtl/bcyc_tmo.sv
module bcyc_tmo #(
  parameter int TMO_CLKS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic expire
);
  localparam int TW = (TMO_CLKS > 1) ? $clog2(TMO_CLKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(TMO_CLKS - 1);

  logic [TW-1:0] cnt;

  assign expire = step && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (step && cnt != LAST) cnt <= cnt + 1'b1;
  end

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/bcyc_seq.sv
module bcyc_seq
  import bcyc_pkg::*;
#(
  parameter int BASE_CLKS = 4,
  parameter int WS_W      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [WS_W-1:0] ws_sel,
  input  logic            tmo_off,
  input  logic [1:0]      phase_tag,
  input  logic            rdy_in,
  input  logic            expire,
  output logic            req_ready,
  output logic            accept,
  output logic            tmo_step,
  output logic            cyc_done,
  output logic            cyc_abort,
  output logic [1:0]      flt_code
);
  localparam int BW = (BASE_CLKS > 2) ? $clog2(BASE_CLKS) : 1;
  localparam logic [BW-1:0] BASE_LAST = BW'(BASE_CLKS - 2);

  bcyc_st_e        st;
  logic [BW-1:0]   bcnt;
  logic [WS_W-1:0] ws_q;
  logic [WS_W-1:0] scnt;
  logic            armed;
  bcyc_flt_e       kind_q;
  bcyc_flt_e       flt_q;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign tmo_step  = (st == ST_HARD) && !rdy_in && armed;
  assign flt_code  = flt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bcnt      <= '0;
      ws_q      <= '0;
      scnt      <= '0;
      armed     <= 1'b0;
      kind_q    <= FLT_NONE;
      flt_q     <= FLT_NONE;
      cyc_done  <= 1'b0;
      cyc_abort <= 1'b0;
    end else begin
      cyc_done  <= 1'b0;
      cyc_abort <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          st     <= ST_BASE;
          bcnt   <= '0;
          ws_q   <= ws_sel;
          armed  <= !tmo_off;
          kind_q <= tag_to_flt(phase_tag);
        end
        ST_BASE: begin
          if (bcnt == BASE_LAST) begin
            if (ws_q != '0) begin
              st   <= ST_SOFT;
              scnt <= ws_q - 1'b1;
            end else begin
              st <= ST_HARD;
            end
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_SOFT: begin
          if (scnt == '0) st <= ST_HARD;
          else            scnt <= scnt - 1'b1;
        end
        ST_HARD: begin
          if (rdy_in) begin
            cyc_done <= 1'b1;
            st       <= ST_IDLE;
          end else if (expire) begin
            cyc_abort <= 1'b1;
            flt_q     <= kind_q;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_done && cyc_abort));
  // R5
  done_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> $past(rdy_in));
  // R7
  abort_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_abort |-> !$past(rdy_in));
  // R9
  abort_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_abort |-> $past(armed));
  // R8
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_abort |-> $stable(flt_code));
  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: rtl/bcyc_ctrl.sv
module bcyc_ctrl #(
  parameter int BASE_CLKS = 4,
  parameter int WS_W      = 2,
  parameter int TMO_CLKS  = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [WS_W-1:0] ws_sel,
  input  logic            tmo_off,
  input  logic [1:0]      phase_tag,
  input  logic            rdy_in,
  output logic            cyc_done,
  output logic            cyc_abort,
  output logic [1:0]      flt_code
);
  logic accept;
  logic tmo_step;
  logic expire;

  bcyc_seq #(.BASE_CLKS(BASE_CLKS), .WS_W(WS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ws_sel(ws_sel),
    .tmo_off(tmo_off), .phase_tag(phase_tag), .rdy_in(rdy_in),
    .expire(expire), .req_ready(req_ready), .accept(accept),
    .tmo_step(tmo_step), .cyc_done(cyc_done), .cyc_abort(cyc_abort),
    .flt_code(flt_code)
  );

  bcyc_tmo #(.TMO_CLKS(TMO_CLKS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(accept), .step(tmo_step), .expire(expire)
  );

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !cyc_done && !cyc_abort));
endmodule

// File: tb/bcyc_ctrl_test.sv
`timescale 1ns/1ps
module bcyc_ctrl_test;
  typedef struct {
    int         due;
    bit         is_abort;
    logic [1:0] code;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] ws_sel = 2'b00;
  logic tmo_off = 1'b0;
  logic [1:0] phase_tag = 2'b00;
  logic rdy_in = 1'b0;
  logic cyc_done, cyc_abort;
  logic [1:0] flt_code;

  int checks = 0;
  int failures = 0;
  int pe = 0;
  int rdy_at = 1 << 30;
  bit finished = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  bcyc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .ws_sel(ws_sel), .tmo_off(tmo_off), .phase_tag(phase_tag),
    .rdy_in(rdy_in), .cyc_done(cyc_done), .cyc_abort(cyc_abort),
    .flt_code(flt_code)
  );

  always @(posedge clk) pe <= pe + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp, pe);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: drives READY and pops the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      rdy_in = (pe + 1 >= rdy_at);
      if (cyc_done && cyc_abort)
        check(0, "R11 both pulses", 1, 0);
      if (cyc_done || cyc_abort) begin
        if (q.size() == 0) begin
          check(0, "R11 unexpected pulse", pe, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(pe == e.due, {e.req, " end edge"}, pe, e.due);
          check(cyc_abort == e.is_abort, {e.req, " abort vs done"}, cyc_abort, e.is_abort);
          if (e.is_abort)
            check(flt_code == e.code, {e.req, " fault code"}, flt_code, e.code);
        end
      end else if (q.size() != 0 && pe > q[0].due) begin
        exp_t e;
        e = q.pop_front();
        check(0, {e.req, " missing end pulse"}, pe, e.due);
      end
    end
  end

  // driver: issue one request, push its expected outcome, wait for it
  task automatic run(input logic [1:0] ws, input bit off, input logic [1:0] tag,
                     input int h, input bit exp_abort, input int lat,
                     input logic [1:0] code, input bit mid_change, input string req);
    int a;
    exp_t e;
    @(negedge clk);
    check(req_ready == 1'b1, "R2 idle ready", req_ready, 1);
    ws_sel = ws; tmo_off = off; phase_tag = tag;
    a = pe + 1;
    rdy_at = (h < 0) ? (1 << 30) : (a + 4 + int'(ws) + h);
    e.due = a + lat; e.is_abort = exp_abort; e.code = code; e.req = req;
    q.push_back(e);
    req_valid = 1'b1;
    @(negedge clk);
    if (mid_change) begin
      ws_sel = ~ws; tmo_off = ~off; phase_tag = ~tag;
    end
    @(negedge clk);
    check(req_ready == 1'b0, "R2 busy blocks", req_ready, 0);
    req_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    rdy_at = 1 << 30;
  endtask

  initial begin
    #(200000 * 4);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    check(!cyc_done && !cyc_abort, "R1 no pulse in reset", cyc_done | cyc_abort, 0);
    check(flt_code == 2'b00, "R1 fault code in reset", flt_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(flt_code == 2'b00, "R1 fault code after reset", flt_code, 0);

    run(2'd0, 0, 2'b00, 0, 0, 4, 2'b00, 0, "R3 base cycle");
    run(2'd1, 0, 2'b00, 0, 0, 5, 2'b00, 0, "R4 one wait");
    run(2'd2, 0, 2'b01, 0, 0, 6, 2'b00, 0, "R4 two waits");
    run(2'd3, 0, 2'b10, 0, 0, 7, 2'b00, 0, "R4 three waits");
    run(2'd2, 0, 2'b00, 5, 0, 11, 2'b00, 0, "R5 ready late");
    run(2'd0, 0, 2'b00, -1, 1, 515, 2'b01, 0, "R6 timeout param");
    run(2'd3, 0, 2'b01, -1, 1, 518, 2'b10, 0, "R8 timeout result");
    run(2'd1, 0, 2'b10, 511, 0, 516, 2'b00, 0, "R7 ready on last sample");
    @(negedge clk);
    check(flt_code == 2'b10, "R8 code held after done", flt_code, 2);
    run(2'd0, 0, 2'b11, -1, 1, 515, 2'b11, 0, "R8 timeout data tag11");
    run(2'd0, 1, 2'b00, 700, 0, 704, 2'b00, 0, "R9 timeout disabled");
    run(2'd0, 0, 2'b00, -1, 1, 515, 2'b01, 1, "R10 settings sampled abort");
    run(2'd2, 0, 2'b01, 3, 0, 9, 2'b00, 1, "R10 settings sampled done");
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R11 scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule